// File: doc/BRIEF.md
# Memory Ordering Queue with Store-Wait Prediction

This block keeps track of in-flight memory instructions between execution and retirement so that a core which runs loads out of order can detect and undo memory ordering mistakes. Stores claim a store-queue slot at dispatch, before their address is known. Later they supply address and data. Loads enter the load queue at the moment they execute. Every instruction carries an age tag, and all ordering decisions compare these tags.

When a store's address arrives, it is compared with every executed load that is younger than the store. If any such load read the same word, that load read stale data. The oldest offender's tag is reported for replay. The offender's low PC bits also set a flag in a small predictor. A later load whose flag is set is told to wait while any older store still lacks an address. When a load executes, it receives data forwarded from the youngest older store that has a matching known address. Retirement frees entries, and a retiring store is handed to the cache write port. A flush removes every entry younger than a given tag from both queues.

Top module: `mem_order_queue`

## Requirements
- R1: After reset both queues are empty. `replay_vld`, `cache_wr_vld`, `lq_full` and `sq_full` are low, and every predictor flag is clear.
- R2: An executing load sees, in the same cycle, `ld_fwd_hit`=1 and `ld_fwd_data` from the youngest store that is older than the load, has a known address and has an address equal to the load's. If no store qualifies, `ld_fwd_hit`=0.
- R3: When a store's address arrives, consider every executed load that is younger than the store and has the same address, including a load entering in that same cycle. If any exists, then in the next cycle `replay_vld` pulses for one cycle and `replay_age` holds the oldest such load's tag.
- R4: Loads that are older than the arriving store, or that have a different address, cause no replay.
- R5: A replay sets the predictor flag indexed by the offending load's `ld_exec_pc_lo`. Aliases sharing those bits share the flag. A load whose flag is set raises `ld_wait` in the same cycle if any older store in the queue has no address yet. A waiting load is not entered into the load queue.
- R6: `ld_wait` stays low when the load's flag is clear, or when every older store already has an address.
- R7: Retiring a store drives `cache_wr_vld` high in the next cycle for exactly one cycle, with that store's address and data, and frees its slot.
- R8: A flush with tag F removes every entry younger than F from both queues and keeps F and everything older. Store and load activity presented in the same cycle as a flush is ignored.
- R9: `lq_full` / `sq_full` are high exactly when every slot of the corresponding queue is occupied.
- R10: Tag A is older than tag B when (A−B) modulo 2^AGE_W has its top bit set. With AGE_W=8, this makes tag 250 older than tag 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_alloc_vld | input | 1 | Store dispatched; claims a store slot |
| st_alloc_age | input | AGE_W | Tag of dispatched store |
| st_exec_vld | input | 1 | Store address and data available |
| st_exec_age | input | AGE_W | Tag of that store |
| st_exec_addr | input | ADDR_W | Store word address |
| st_exec_data | input | DATA_W | Store data |
| ld_exec_vld | input | 1 | Load executes this cycle |
| ld_exec_age | input | AGE_W | Tag of the load |
| ld_exec_pc_lo | input | PIDX_W | Low PC bits of the load (predictor index) |
| ld_exec_addr | input | ADDR_W | Load word address |
| ld_wait | output | 1 | Load must hold back; not accepted |
| ld_fwd_hit | output | 1 | Store data forwarded to the load |
| ld_fwd_data | output | DATA_W | Forwarded data |
| retire_vld | input | 1 | An instruction retires |
| retire_age | input | AGE_W | Tag of retiring instruction |
| flush_vld | input | 1 | Discard younger entries |
| flush_age | input | AGE_W | Youngest tag that survives |
| replay_vld | output | 1 | Ordering violation found |
| replay_age | output | AGE_W | Tag of load to replay |
| cache_wr_vld | output | 1 | Retired store write to cache |
| cache_wr_addr | output | ADDR_W | Write address |
| cache_wr_data | output | DATA_W | Write data |
| lq_full | output | 1 | Load queue has no free slot |
| sq_full | output | 1 | Store queue has no free slot |

## Verification
The bench builds the block with four slots per queue, a 16-entry predictor and 16-bit addresses and data. The shallow queues let the full flags and slot reuse be reached with a handful of instructions. The small predictor lets two PCs 16 apart alias on the same flag, which the bench exercises. The 8-bit tag width is kept so that a store with tag 250 and a load with tag 2 cross the wrap point, which tests the modular age comparison.

// File: rtl/mq_pkg.sv
package mq_pkg;
  localparam int AGE_W = 8;

  // a is older than b under modular tag arithmetic
  function automatic logic is_older(input logic [AGE_W-1:0] a, input logic [AGE_W-1:0] b);
    logic [AGE_W-1:0] d;
    d = a - b;
    return d[AGE_W-1];
  endfunction
endpackage

// File: rtl/mq_store_q.sv
module mq_store_q
  import mq_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_vld,
  input  logic [AGE_W-1:0]  alloc_age,
  input  logic              exec_vld,
  input  logic [AGE_W-1:0]  exec_age,
  input  logic [ADDR_W-1:0] exec_addr,
  input  logic [DATA_W-1:0] exec_data,
  input  logic              retire_vld,
  input  logic [AGE_W-1:0]  retire_age,
  input  logic              flush_vld,
  input  logic [AGE_W-1:0]  flush_age,
  input  logic [AGE_W-1:0]  probe_age,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic              full,
  output logic              fwd_hit,
  output logic [DATA_W-1:0] fwd_data,
  output logic              unknown_older,
  output logic              drain_vld,
  output logic [ADDR_W-1:0] drain_addr,
  output logic [DATA_W-1:0] drain_data
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]  vld_q, vld_d, known_q, known_d, pay_we;
  logic [AGE_W-1:0]  age_q [DEPTH];
  logic [AGE_W-1:0]  age_d [DEPTH];
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [ADDR_W-1:0] addr_d [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [DATA_W-1:0] data_d [DEPTH];
  logic [IDX_W-1:0]  free_idx;
  logic              free_found;
  logic [AGE_W-1:0]  best_age;
  logic              drain_vld_d, drain_vld_q, drain_we;
  logic [ADDR_W-1:0] drain_addr_d, drain_addr_q;
  logic [DATA_W-1:0] drain_data_d, drain_data_q;

  assign full = &vld_q;

  // lowest free slot
  always_comb begin
    free_idx   = '0;
    free_found = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!vld_q[i] && !free_found) begin
        free_idx   = IDX_W'(i);
        free_found = 1'b1;
      end
    end
  end

  // next state of the slots
  always_comb begin
    vld_d        = vld_q;
    known_d      = known_q;
    pay_we       = '0;
    drain_vld_d  = 1'b0;
    drain_we     = 1'b0;
    drain_addr_d = drain_addr_q;
    drain_data_d = drain_data_q;
    for (int i = 0; i < DEPTH; i++) begin
      age_d[i]  = age_q[i];
      addr_d[i] = addr_q[i];
      data_d[i] = data_q[i];
      if (vld_q[i] && exec_vld && age_q[i] == exec_age) begin
        known_d[i] = 1'b1;
        addr_d[i]  = exec_addr;
        data_d[i]  = exec_data;
        pay_we[i]  = 1'b1;
      end
      if (vld_q[i] && retire_vld && age_q[i] == retire_age) begin
        vld_d[i]     = 1'b0;
        drain_vld_d  = 1'b1;
        drain_we     = 1'b1;
        drain_addr_d = addr_q[i];
        drain_data_d = data_q[i];
      end
      if (vld_q[i] && flush_vld && is_older(flush_age, age_q[i])) begin
        vld_d[i] = 1'b0;
      end
    end
    if (alloc_vld && free_found) begin
      vld_d[free_idx]   = 1'b1;
      known_d[free_idx] = 1'b0;
      age_d[free_idx]   = alloc_age;
      pay_we[free_idx]  = 1'b1;
    end
  end

  // load probe: youngest older known match, and any older store lacking an address
  always_comb begin
    fwd_hit       = 1'b0;
    fwd_data      = '0;
    best_age      = '0;
    unknown_older = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld_q[i] && is_older(age_q[i], probe_age)) begin
        if (!known_q[i]) begin
          unknown_older = 1'b1;
        end else if (addr_q[i] == probe_addr && (!fwd_hit || is_older(best_age, age_q[i]))) begin
          fwd_hit  = 1'b1;
          fwd_data = data_q[i];
          best_age = age_q[i];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q       <= '0;
      known_q     <= '0;
      drain_vld_q <= 1'b0;
    end else begin
      vld_q       <= vld_d;
      known_q     <= known_d;
      drain_vld_q <= drain_vld_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (pay_we[i]) begin
        age_q[i]  <= age_d[i];
        addr_q[i] <= addr_d[i];
        data_q[i] <= data_d[i];
      end
    end
    if (drain_we) begin
      drain_addr_q <= drain_addr_d;
      drain_data_q <= drain_data_d;
    end
  end

  assign drain_vld  = drain_vld_q;
  assign drain_addr = drain_addr_q;
  assign drain_data = drain_data_q;
endmodule

// File: rtl/mq_load_q.sv
module mq_load_q
  import mq_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 32,
  parameter int PIDX_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_vld,
  input  logic [AGE_W-1:0]  ins_age,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic [PIDX_W-1:0] ins_pc,
  input  logic              retire_vld,
  input  logic [AGE_W-1:0]  retire_age,
  input  logic              flush_vld,
  input  logic [AGE_W-1:0]  flush_age,
  input  logic [AGE_W-1:0]  probe_age,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic              full,
  output logic              hit,
  output logic [AGE_W-1:0]  hit_age,
  output logic [PIDX_W-1:0] hit_pc
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]  vld_q, vld_d, pay_we;
  logic [AGE_W-1:0]  age_q [DEPTH];
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [PIDX_W-1:0] pc_q [DEPTH];
  logic [IDX_W-1:0]  free_idx;
  logic              free_found;

  assign full = &vld_q;

  always_comb begin
    free_idx   = '0;
    free_found = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!vld_q[i] && !free_found) begin
        free_idx   = IDX_W'(i);
        free_found = 1'b1;
      end
    end
  end

  always_comb begin
    vld_d  = vld_q;
    pay_we = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld_q[i] && retire_vld && age_q[i] == retire_age) vld_d[i] = 1'b0;
      if (vld_q[i] && flush_vld && is_older(flush_age, age_q[i])) vld_d[i] = 1'b0;
    end
    if (ins_vld && free_found) begin
      vld_d[free_idx]  = 1'b1;
      pay_we[free_idx] = 1'b1;
    end
  end

  // store probe: oldest executed younger load on the same word
  always_comb begin
    hit     = 1'b0;
    hit_age = '0;
    hit_pc  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld_q[i] && is_older(probe_age, age_q[i]) && addr_q[i] == probe_addr &&
          (!hit || is_older(age_q[i], hit_age))) begin
        hit     = 1'b1;
        hit_age = age_q[i];
        hit_pc  = pc_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (pay_we[i]) begin
        age_q[i]  <= ins_age;
        addr_q[i] <= ins_addr;
        pc_q[i]   <= ins_pc;
      end
    end
  end
endmodule

// File: rtl/mq_wait_pred.sv
module mq_wait_pred #(
  parameter int ENTRIES = 64,
  parameter int PIDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PIDX_W-1:0] look_pc,
  output logic              look_flag,
  input  logic              train_vld,
  input  logic [PIDX_W-1:0] train_pc
);
  logic [ENTRIES-1:0] flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (train_vld) flag_d[train_pc] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flag_q <= '0;
    else if (train_vld) flag_q <= flag_d;
  end

  assign look_flag = flag_q[look_pc];
endmodule

// File: rtl/mem_order_queue.sv
module mem_order_queue
  import mq_pkg::*;
#(
  parameter int QDEPTH       = 32,
  parameter int ADDR_W       = 32,
  parameter int DATA_W       = 32,
  parameter int PRED_ENTRIES = 64,
  localparam int PIDX_W      = $clog2(PRED_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_alloc_vld,
  input  logic [AGE_W-1:0]  st_alloc_age,
  input  logic              st_exec_vld,
  input  logic [AGE_W-1:0]  st_exec_age,
  input  logic [ADDR_W-1:0] st_exec_addr,
  input  logic [DATA_W-1:0] st_exec_data,
  input  logic              ld_exec_vld,
  input  logic [AGE_W-1:0]  ld_exec_age,
  input  logic [PIDX_W-1:0] ld_exec_pc_lo,
  input  logic [ADDR_W-1:0] ld_exec_addr,
  output logic              ld_wait,
  output logic              ld_fwd_hit,
  output logic [DATA_W-1:0] ld_fwd_data,
  input  logic              retire_vld,
  input  logic [AGE_W-1:0]  retire_age,
  input  logic              flush_vld,
  input  logic [AGE_W-1:0]  flush_age,
  output logic              replay_vld,
  output logic [AGE_W-1:0]  replay_age,
  output logic              cache_wr_vld,
  output logic [ADDR_W-1:0] cache_wr_addr,
  output logic [DATA_W-1:0] cache_wr_data,
  output logic              lq_full,
  output logic              sq_full
);
  logic [1:0]        rst_sync_q;
  logic              rst_n_i;
  logic              st_alloc_ok, st_exec_ok, ld_exec_ok, ld_ins;
  logic              sq_fwd_hit, sq_unknown_older, pred_flag;
  logic              lq_hit, inc_hit, viol;
  logic [AGE_W-1:0]  lq_hit_age, viol_age;
  logic [PIDX_W-1:0] lq_hit_pc, viol_pc;
  logic              replay_vld_d, replay_vld_q;
  logic [AGE_W-1:0]  replay_age_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  assign st_alloc_ok = st_alloc_vld && !flush_vld;
  assign st_exec_ok  = st_exec_vld  && !flush_vld;
  assign ld_exec_ok  = ld_exec_vld  && !flush_vld;
  assign ld_wait     = ld_exec_vld && pred_flag && sq_unknown_older;
  assign ld_fwd_hit  = ld_exec_vld && sq_fwd_hit;
  assign ld_ins      = ld_exec_ok && !ld_wait;

  mq_store_q #(.DEPTH(QDEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sq (
    .clk(clk), .rst_n(rst_n_i),
    .alloc_vld(st_alloc_ok), .alloc_age(st_alloc_age),
    .exec_vld(st_exec_ok), .exec_age(st_exec_age), .exec_addr(st_exec_addr), .exec_data(st_exec_data),
    .retire_vld(retire_vld), .retire_age(retire_age),
    .flush_vld(flush_vld), .flush_age(flush_age),
    .probe_age(ld_exec_age), .probe_addr(ld_exec_addr),
    .full(sq_full), .fwd_hit(sq_fwd_hit), .fwd_data(ld_fwd_data), .unknown_older(sq_unknown_older),
    .drain_vld(cache_wr_vld), .drain_addr(cache_wr_addr), .drain_data(cache_wr_data)
  );

  mq_load_q #(.DEPTH(QDEPTH), .ADDR_W(ADDR_W), .PIDX_W(PIDX_W)) u_lq (
    .clk(clk), .rst_n(rst_n_i),
    .ins_vld(ld_ins), .ins_age(ld_exec_age), .ins_addr(ld_exec_addr), .ins_pc(ld_exec_pc_lo),
    .retire_vld(retire_vld), .retire_age(retire_age),
    .flush_vld(flush_vld), .flush_age(flush_age),
    .probe_age(st_exec_age), .probe_addr(st_exec_addr),
    .full(lq_full), .hit(lq_hit), .hit_age(lq_hit_age), .hit_pc(lq_hit_pc)
  );

  mq_wait_pred #(.ENTRIES(PRED_ENTRIES), .PIDX_W(PIDX_W)) u_pred (
    .clk(clk), .rst_n(rst_n_i),
    .look_pc(ld_exec_pc_lo), .look_flag(pred_flag),
    .train_vld(viol), .train_pc(viol_pc)
  );

  // a load entering this very cycle is also exposed to the arriving store
  assign inc_hit = ld_ins && is_older(st_exec_age, ld_exec_age) && ld_exec_addr == st_exec_addr;

  always_comb begin
    viol     = st_exec_ok && (lq_hit || inc_hit);
    viol_age = lq_hit_age;
    viol_pc  = lq_hit_pc;
    if (inc_hit && (!lq_hit || is_older(ld_exec_age, lq_hit_age))) begin
      viol_age = ld_exec_age;
      viol_pc  = ld_exec_pc_lo;
    end
    replay_vld_d = viol;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) replay_vld_q <= 1'b0;
    else          replay_vld_q <= replay_vld_d;
  end

  always_ff @(posedge clk) begin
    if (viol) replay_age_q <= viol_age;
  end

  assign replay_vld = replay_vld_q;
  assign replay_age = replay_age_q;
endmodule

// File: rtl/mq_order_chk.sv
module mq_order_chk
  import mq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             st_exec_vld,
  input logic [AGE_W-1:0] st_exec_age,
  input logic             ld_exec_vld,
  input logic             ld_fwd_hit,
  input logic             ld_wait,
  input logic             retire_vld,
  input logic             flush_vld,
  input logic             replay_vld,
  input logic [AGE_W-1:0] replay_age,
  input logic             cache_wr_vld
);
  // R3
  replay_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    replay_vld |-> $past(st_exec_vld && !flush_vld));

  // R3
  replay_younger_chk: assert property (@(posedge clk) disable iff (!rst_n)
    replay_vld |-> is_older($past(st_exec_age), replay_age));

  // R7
  drain_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cache_wr_vld |-> $past(retire_vld));

  // R8
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_vld |=> !replay_vld);

  // R2
  fwd_needs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fwd_hit |-> ld_exec_vld);

  // R5
  wait_needs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_wait |-> ld_exec_vld);
endmodule

bind mem_order_queue mq_order_chk u_mq_order_chk (
  .clk(clk), .rst_n(rst_n),
  .st_exec_vld(st_exec_vld), .st_exec_age(st_exec_age),
  .ld_exec_vld(ld_exec_vld), .ld_fwd_hit(ld_fwd_hit), .ld_wait(ld_wait),
  .retire_vld(retire_vld), .flush_vld(flush_vld),
  .replay_vld(replay_vld), .replay_age(replay_age), .cache_wr_vld(cache_wr_vld)
);

// File: tb/test_mem_order_queue.sv
`timescale 1ns/1ps
module test_mem_order_queue;
  import mq_pkg::*;
  localparam int QD = 4;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int PE = 16;
  localparam int PW = $clog2(PE);

  logic clk = 1'b0;
  logic rst_n;
  logic st_alloc_vld, st_exec_vld, ld_exec_vld, retire_vld, flush_vld;
  logic [AGE_W-1:0] st_alloc_age, st_exec_age, ld_exec_age, retire_age, flush_age, replay_age;
  logic [AW-1:0] st_exec_addr, ld_exec_addr, cache_wr_addr;
  logic [DW-1:0] st_exec_data, ld_fwd_data, cache_wr_data;
  logic [PW-1:0] ld_exec_pc_lo;
  logic ld_wait, ld_fwd_hit, replay_vld, cache_wr_vld, lq_full, sq_full;
  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mem_order_queue #(.QDEPTH(QD), .ADDR_W(AW), .DATA_W(DW), .PRED_ENTRIES(PE)) i_mem_order_queue (
    .clk(clk), .rst_n(rst_n),
    .st_alloc_vld(st_alloc_vld), .st_alloc_age(st_alloc_age),
    .st_exec_vld(st_exec_vld), .st_exec_age(st_exec_age), .st_exec_addr(st_exec_addr), .st_exec_data(st_exec_data),
    .ld_exec_vld(ld_exec_vld), .ld_exec_age(ld_exec_age), .ld_exec_pc_lo(ld_exec_pc_lo), .ld_exec_addr(ld_exec_addr),
    .ld_wait(ld_wait), .ld_fwd_hit(ld_fwd_hit), .ld_fwd_data(ld_fwd_data),
    .retire_vld(retire_vld), .retire_age(retire_age), .flush_vld(flush_vld), .flush_age(flush_age),
    .replay_vld(replay_vld), .replay_age(replay_age),
    .cache_wr_vld(cache_wr_vld), .cache_wr_addr(cache_wr_addr), .cache_wr_data(cache_wr_data),
    .lq_full(lq_full), .sq_full(sq_full)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    st_alloc_vld = 0; st_alloc_age = 0;
    st_exec_vld = 0; st_exec_age = 0; st_exec_addr = 0; st_exec_data = 0;
    ld_exec_vld = 0; ld_exec_age = 0; ld_exec_pc_lo = 0; ld_exec_addr = 0;
    retire_vld = 0; retire_age = 0; flush_vld = 0; flush_age = 0;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  // all helpers start and end just after a falling edge
  task automatic st_alloc(input logic [AGE_W-1:0] a);
    st_alloc_vld = 1; st_alloc_age = a;
    @(negedge clk); idle_inputs();
  endtask

  task automatic st_exec(input logic [AGE_W-1:0] a, input logic [AW-1:0] ad, input logic [DW-1:0] d);
    st_exec_vld = 1; st_exec_age = a; st_exec_addr = ad; st_exec_data = d;
    @(negedge clk); idle_inputs();
  endtask

  task automatic ld_exec(input string req, input logic [AGE_W-1:0] a, input logic [PW-1:0] pc,
                         input logic [AW-1:0] ad, input logic ew, input logic eh, input logic [DW-1:0] ed);
    ld_exec_vld = 1; ld_exec_age = a; ld_exec_pc_lo = pc; ld_exec_addr = ad;
    #1;
    chk({req, " wait"}, 32'(ld_wait), 32'(ew));
    chk({req, " fwd_hit"}, 32'(ld_fwd_hit), 32'(eh));
    if (eh) chk({req, " fwd_data"}, 32'(ld_fwd_data), 32'(ed));
    @(negedge clk); idle_inputs();
  endtask

  task automatic retire(input logic [AGE_W-1:0] a);
    retire_vld = 1; retire_age = a;
    @(negedge clk); idle_inputs();
  endtask

  task automatic flush(input logic [AGE_W-1:0] a);
    flush_vld = 1; flush_age = a;
    @(negedge clk); idle_inputs();
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R1 replay", 32'(replay_vld), 0);
    chk("R1 cache_wr", 32'(cache_wr_vld), 0);
    chk("R1 lq_full", 32'(lq_full), 0);
    chk("R1 sq_full", 32'(sq_full), 0);
    st_alloc(8'd1);
    ld_exec("R1 predictor clear", 8'd2, 4'h3, 16'h40, 0, 0, 0);
  endtask

  task automatic t_forward();
    do_reset();
    st_alloc(8'd1); st_alloc(8'd3);
    st_exec(8'd1, 16'h10, 16'hAAAA);
    st_exec(8'd3, 16'h10, 16'hBBBB);
    ld_exec("R2 youngest older", 8'd5, 4'h1, 16'h10, 0, 1, 16'hBBBB);
    ld_exec("R2 between stores", 8'd2, 4'h1, 16'h10, 0, 1, 16'hAAAA);
    ld_exec("R2 older than all", 8'd0, 4'h1, 16'h10, 0, 0, 0);
    ld_exec("R2 other address", 8'd6, 4'h1, 16'h12, 0, 0, 0);
  endtask

  task automatic t_violation();
    do_reset();
    st_alloc(8'd1);
    ld_exec("R3 setup", 8'd6, 4'h2, 16'h40, 0, 0, 0);
    ld_exec("R3 setup", 8'd4, 4'h2, 16'h40, 0, 0, 0);
    ld_exec("R4 setup", 8'd3, 4'h2, 16'h44, 0, 0, 0);
    ld_exec("R4 setup", 8'd0, 4'h2, 16'h40, 0, 0, 0);
    st_exec(8'd1, 16'h40, 16'h5);
    chk("R3 replay", 32'(replay_vld), 1);
    chk("R3 oldest age", 32'(replay_age), 4);
    @(negedge clk);
    chk("R3 one-cycle pulse", 32'(replay_vld), 0);
    // R4: store younger than every matching load
    do_reset();
    st_alloc(8'd9);
    ld_exec("R4 setup", 8'd2, 4'h2, 16'h40, 0, 0, 0);
    st_exec(8'd9, 16'h40, 16'h5);
    chk("R4 older load ignored", 32'(replay_vld), 0);
  endtask

  task automatic t_same_cycle();
    do_reset();
    st_alloc(8'd1);
    st_exec_vld = 1; st_exec_age = 8'd1; st_exec_addr = 16'h80; st_exec_data = 16'h7;
    ld_exec_vld = 1; ld_exec_age = 8'd3; ld_exec_pc_lo = 4'h1; ld_exec_addr = 16'h80;
    @(negedge clk); idle_inputs();
    chk("R3 same-cycle replay", 32'(replay_vld), 1);
    chk("R3 same-cycle age", 32'(replay_age), 3);
  endtask

  task automatic t_predictor();
    do_reset();
    st_alloc(8'd1);
    ld_exec("R5 train", 8'd4, 4'h3, 16'h40, 0, 0, 0);
    st_exec(8'd1, 16'h40, 16'h5);
    chk("R5 train replay", 32'(replay_vld), 1);
    st_alloc(8'd8);
    ld_exec("R5 flagged waits", 8'd9, 4'h3, 16'h50, 1, 0, 0);
    ld_exec("R6 other pc", 8'd9, 4'h4, 16'h58, 0, 0, 0);
    ld_exec("R6 no older unknown", 8'd7, 4'h3, 16'h5C, 0, 0, 0);
    st_exec(8'd8, 16'h50, 16'h77);
    chk("R5 waiting load not entered", 32'(replay_vld), 0);
    ld_exec("R6 older stores known", 8'd9, 4'h3, 16'h50, 0, 1, 16'h77);
  endtask

  task automatic t_alias();
    do_reset();
    st_alloc(8'd1);
    // pc 0x23 and 0x33 share low 4 bits
    ld_exec("R5 alias train", 8'd4, 4'h3, 16'h40, 0, 0, 0);
    st_exec(8'd1, 16'h40, 16'h5);
    st_alloc(8'd10);
    ld_exec("R5 alias waits", 8'd11, 4'(8'h33), 16'h90, 1, 0, 0);
  endtask

  task automatic t_retire();
    do_reset();
    st_alloc(8'd1);
    st_exec(8'd1, 16'h7, 16'h1234);
    retire(8'd1);
    chk("R7 cache_wr", 32'(cache_wr_vld), 1);
    chk("R7 addr", 32'(cache_wr_addr), 32'h7);
    chk("R7 data", 32'(cache_wr_data), 32'h1234);
    @(negedge clk);
    chk("R7 single pulse", 32'(cache_wr_vld), 0);
    ld_exec("R7 slot freed", 8'd2, 4'h0, 16'h7, 0, 0, 0);
  endtask

  task automatic t_full();
    do_reset();
    for (int i = 1; i <= QD; i++) st_alloc(8'(i));
    chk("R9 sq_full", 32'(sq_full), 1);
    retire(8'd1);
    chk("R9 sq not full after retire", 32'(sq_full), 0);
    for (int i = 0; i < QD; i++) ld_exec("R9 fill lq", 8'(20 + i), 4'h0, 16'(16'h100 + i), 0, 0, 0);
    chk("R9 lq_full", 32'(lq_full), 1);
    retire(8'd20);
    chk("R9 lq not full after retire", 32'(lq_full), 0);
  endtask

  task automatic t_flush();
    do_reset();
    st_alloc(8'd1); st_alloc(8'd2); st_alloc(8'd3);
    st_exec(8'd1, 16'h60, 16'h11);
    st_exec(8'd3, 16'h60, 16'h33);
    flush(8'd1);
    ld_exec("R8 younger store gone", 8'd5, 4'h0, 16'h60, 0, 1, 16'h11);
    do_reset();
    st_alloc(8'd2);
    ld_exec("R8 setup", 8'd6, 4'h0, 16'h70, 0, 0, 0);
    ld_exec("R8 setup", 8'd4, 4'h0, 16'h74, 0, 0, 0);
    flush(8'd4);
    st_exec(8'd2, 16'h70, 16'h1);
    chk("R8 younger load gone", 32'(replay_vld), 0);
    st_exec(8'd2, 16'h74, 16'h1);
    chk("R8 tag itself kept", 32'(replay_vld), 1);
    chk("R8 kept age", 32'(replay_age), 4);
  endtask

  task automatic t_wrap();
    do_reset();
    st_alloc(8'd250);
    ld_exec("R10 setup", 8'd2, 4'h5, 16'h90, 0, 0, 0);
    st_exec(8'd250, 16'h90, 16'h9);
    chk("R10 wrap replay", 32'(replay_vld), 1);
    chk("R10 wrap age", 32'(replay_age), 2);
  endtask

  initial begin
    rst_n = 0;
    idle_inputs();
    @(negedge clk);
    t_reset_state();
    t_forward();
    t_violation();
    t_same_cycle();
    t_predictor();
    t_alias();
    t_retire();
    t_full();
    t_flush();
    t_wrap();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule